// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a two-port shared memory and watches the accesses each port makes. Two words at the top of the address space act as message slots. The topmost word is the slot owned by the right port, and the word just below it is the slot owned by the left port. When one port stores a word into the slot owned by the other port, the owner receives an active-low interrupt. The owner clears that interrupt by reading its own slot. The message data stays in the memory array, which lies outside this block.

Each port supplies a select, a write strobe, a read strobe, an address and a busy indication. Busy comes from the arbitration logic outside this block. While a port is busy, its accesses neither raise nor clear interrupts. All inputs are sampled on the rising clock edge, and each interrupt output is a register, so any change appears one cycle after the access that caused it.

Top module: `dp_mailbox_irq`

## Requirements
- R1: While reset is active, and right after it is released, both interrupt outputs are high (deasserted).
- R2: A selected, non-busy left-port write to the all-ones address drives `r_irq_n` low one cycle later.
- R3: A selected, non-busy right-port write to address all-ones minus one drives `l_irq_n` low one cycle later.
- R4: A selected, non-busy read by the owner of its own slot returns that owner's interrupt output high one cycle later. The right port owns all-ones and the left port owns all-ones minus one.
- R5: A read by a port of the other port's slot leaves both interrupt outputs unchanged.
- R6: While the writing port's busy input is high, its write to the other port's slot does not assert the interrupt.
- R7: While the reading port's busy input is high, its read of its own slot does not clear its interrupt.
- R8: When a set and a clear of the same interrupt happen in the same cycle, the interrupt ends asserted (low).
- R9: Accesses with the port select low have no effect on either interrupt. The same holds for accesses to any other address and for a port writing its own slot.
- R10: When the write and read strobes of a port are both high, the access counts only as a write. It therefore cannot clear an interrupt.
- R11: In every cycle with no set and no clear for an interrupt, that interrupt output holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left port select |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | AW | Left address |
| l_busy | input | 1 | Left busy, active high |
| r_en | input | 1 | Right port select |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | AW | Right address |
| r_busy | input | 1 | Right busy, active high |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions check the following on every cycle:
- every set makes its interrupt low in the next cycle, and set wins over clear;
- every clear without a competing set makes its interrupt high in the next cycle;
- an interrupt with neither a set nor a clear stays stable;
- both outputs are high after reset.

Some behaviours only the bench's scenarios can show, because they are defined by which decoded events must not occur. These are:
- the busy gating;
- that a non-owner read is ignored;
- that a port writing its own slot is ignored;
- that a simultaneous write and read counts only as a write.

The bench shows each of these with a directed sequence and follows it with biased random traffic.

// File: rtl/dp_mailbox_irq.sv
module dp_mailbox_irq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_rd,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  localparam logic [AW-1:0] R_SLOT = {AW{1'b1}};
  localparam logic [AW-1:0] L_SLOT = {{(AW-1){1'b1}}, 1'b0};

  logic l_write, l_read, r_write, r_read;
  logic set_r, clr_r, set_l, clr_l;
  logic flag_l, flag_r;

  assign l_write = l_en & l_wr & ~l_busy;
  assign l_read  = l_en & l_rd & ~l_wr & ~l_busy;
  assign r_write = r_en & r_wr & ~r_busy;
  assign r_read  = r_en & r_rd & ~r_wr & ~r_busy;

  assign set_r = l_write & (l_addr == R_SLOT);
  assign clr_r = r_read  & (r_addr == R_SLOT);
  assign set_l = r_write & (r_addr == L_SLOT);
  assign clr_l = l_read  & (l_addr == L_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_l <= 1'b0;
      flag_r <= 1'b0;
    end else begin
      flag_l <= set_l | (flag_l & ~clr_l);
      flag_r <= set_r | (flag_r & ~clr_r);
    end
  end

  assign l_irq_n = ~flag_l;
  assign r_irq_n = ~flag_r;
endmodule

// File: rtl/dp_mailbox_irq_props.sv
module dp_mailbox_irq_props #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_en,
  input logic          l_wr,
  input logic          l_rd,
  input logic [AW-1:0] l_addr,
  input logic          l_busy,
  input logic          r_en,
  input logic          r_wr,
  input logic          r_rd,
  input logic [AW-1:0] r_addr,
  input logic          r_busy,
  input logic          l_irq_n,
  input logic          r_irq_n
);
  logic [AW-1:0] top_a, nxt_a;
  logic ev_set_r, ev_clr_r, ev_set_l, ev_clr_l;

  assign top_a = {AW{1'b1}};
  assign nxt_a = top_a - 1'b1;
  assign ev_set_r = l_en && l_wr && !l_busy && l_addr == top_a;
  assign ev_set_l = r_en && r_wr && !r_busy && r_addr == nxt_a;
  assign ev_clr_r = r_en && r_rd && !r_wr && !r_busy && r_addr == top_a;
  assign ev_clr_l = l_en && l_rd && !l_wr && !l_busy && l_addr == nxt_a;

  a_r1_reset_high: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n));
  a_r2_right_set: assert property (@(posedge clk) disable iff (!rst_n) ev_set_r |=> !r_irq_n);
  a_r3_left_set: assert property (@(posedge clk) disable iff (!rst_n) ev_set_l |=> !l_irq_n);
  a_r4_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr_r && !ev_set_r) |=> r_irq_n);
  a_r4_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr_l && !ev_set_l) |=> l_irq_n);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set_l && ev_clr_l) |=> !l_irq_n);
  a_r11_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_set_r && !ev_clr_r) |=> $stable(r_irq_n));
  a_r11_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_set_l && !ev_clr_l) |=> $stable(l_irq_n));
endmodule

bind dp_mailbox_irq dp_mailbox_irq_props #(.AW(AW)) u_props (.*);

// File: tb/dp_mailbox_irq_test.sv
module dp_mailbox_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] RS = {AW{1'b1}};
  localparam logic [AW-1:0] LS = {AW{1'b1}} - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_wr = 0, l_rd = 0, l_busy = 0;
  logic r_en = 0, r_wr = 0, r_rd = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  logic exp_l = 1'b0, exp_r = 1'b0;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_mailbox_irq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_busy(l_busy),
    .r_en(r_en), .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  function automatic logic next_flag(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  function automatic logic is_write(logic en, logic wr, logic busy);
    return en && wr && !busy;
  endfunction

  function automatic logic is_read(logic en, logic wr, logic rd, logic busy);
    return en && rd && !wr && !busy;
  endfunction

  task automatic check(string tag, string name, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: %s=%b expected %b", tag, name, act, exp);
    end
  endtask

  task automatic cyc(string tag,
                     logic le, logic lw, logic lr, logic [AW-1:0] la, logic lb,
                     logic re, logic rw, logic rr, logic [AW-1:0] ra, logic rb);
    l_en = le; l_wr = lw; l_rd = lr; l_addr = la; l_busy = lb;
    r_en = re; r_wr = rw; r_rd = rr; r_addr = ra; r_busy = rb;
    exp_r = next_flag(exp_r, is_write(le, lw, lb) && la == RS, is_read(re, rw, rr, rb) && ra == RS);
    exp_l = next_flag(exp_l, is_write(re, rw, rb) && ra == LS, is_read(le, lw, lr, lb) && la == LS);
    @(negedge clk);
    check(tag, "l_irq_n", l_irq_n, ~exp_l);
    check(tag, "r_irq_n", r_irq_n, ~exp_r);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    case ($urandom % 4)
      0: return RS;
      1: return LS;
      default: return AW'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    check("R1", "l_irq_n", l_irq_n, 1'b1);
    check("R1", "r_irq_n", r_irq_n, 1'b1);
    rst_n = 1'b1;
    cyc("R1", 0,0,0,'0,0, 0,0,0,'0,0);
    cyc("R2", 1,1,0,RS,0, 0,0,0,'0,0);
    cyc("R5", 1,0,1,RS,0, 0,0,0,'0,0);
    cyc("R9", 0,0,0,'0,0, 1,1,0,RS,0);
    cyc("R7", 0,0,0,'0,0, 1,0,1,RS,1);
    cyc("R10", 0,0,0,'0,0, 1,1,1,RS,0);
    cyc("R4", 0,0,0,'0,0, 1,0,1,RS,0);
    cyc("R6", 1,1,0,RS,1, 0,0,0,'0,0);
    cyc("R3", 0,0,0,'0,0, 1,1,0,LS,0);
    cyc("R5", 0,0,0,'0,0, 1,0,1,LS,0);
    cyc("R10", 1,1,1,LS,0, 0,0,0,'0,0);
    cyc("R7", 1,0,1,LS,1, 0,0,0,'0,0);
    cyc("R4", 1,0,1,LS,0, 0,0,0,'0,0);
    cyc("R8", 1,0,1,LS,0, 1,1,0,LS,0);
    cyc("R4", 1,0,1,LS,0, 0,0,0,'0,0);
    cyc("R9", 0,0,0,LS,0, 0,1,0,LS,0);
    cyc("R9", 0,0,0,'0,0, 1,1,0,LS-1,0);
    cyc("R6", 0,0,0,'0,0, 1,1,0,LS,1);
    for (int i = 0; i < 4000; i++) begin
      cyc("R11",
          1'($urandom), 1'($urandom), 1'($urandom), pick_addr(), ($urandom % 4) == 0,
          1'($urandom), 1'($urandom), 1'($urandom), pick_addr(), ($urandom % 4) == 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule